// File: doc/BRIEF.md
# Burst DMA Transmitter

This block is the device end of a multiword DMA read path in an optical-drive emulator. Words from the storage side are pushed into a local FIFO. The block streams them one 16-bit word at a time to a host that controls the transfer with an active-low acknowledge and an active-low read strobe. A transfer starts when a word count is loaded. The block raises its request line once the FIFO holds enough data for the next 16-word burst, or for the rest of the transfer if that is shorter.

The host strobe and acknowledge are asynchronous to the system clock, so both pass through two-flop synchronisers. Each synchronised falling edge of the read strobe, seen while acknowledge is low, moves the next FIFO word into the bus register. The host latches that word on its following rising edge. If the FIFO runs short at a burst boundary, the block pauses by dropping its request line, and raises it again once enough words have arrived. The block counts 1024-word sectors and raises an interrupt when the transfer ends. The pad-level tri-state buffer sits outside this block and is controlled by the output-enable port.

Top module: `burst_dma_tx`

## Requirements
- R1: A word offered on `load_i` is stored when the FIFO is not full. A word offered while `fifo_full_o` is high is discarded. `fifo_full_o` is high exactly when the FIFO holds FIFO_DEPTH (default 32) words.
- R2: `bus_oe_o` is a register that is high in the cycle after a clock edge at which `host_ack_n_i` was low and `host_chan_sel_i` was high, and is low otherwise. The bus is therefore released within one clock of acknowledge rising.
- R3: `xfer_req_o` rises only during a transfer whose word count has not run out, and only once the FIFO holds at least min(16, words remaining) words.
- R4: Inside a burst, meaning the number of words delivered so far is not a multiple of 16, `xfer_req_o` stays high. At a burst boundary it drops if the FIFO holds fewer than min(16, words remaining) words, and it rises again when that many are present.
- R5: A falling edge of `host_rd_n_i` that occurs while acknowledge is low and the transfer is active pops the FIFO head into `bus_data_o`. The new word is visible after the third rising clock edge following the strobe change, and words arrive in FIFO order.
- R6: `sector_done_o` pulses for one cycle each time the words delivered within the current transfer reach a multiple of 1024.
- R7: When the last word of the transfer is delivered, `xfer_done_o` pulses for one cycle, `xfer_req_o` is low from the following cycle, and `irq_o` goes high.
- R8: `irq_o` stays high until `irq_clr_i` is sampled high. A completion in the same cycle as a clear takes priority.
- R9: During and right after reset, `xfer_req_o`, `bus_oe_o`, `bus_data_o`, `sector_done_o`, `xfer_done_o`, `irq_o` and `fifo_full_o` are all zero.
- R10: A `start_i` pulse that carries a zero length, or that arrives while a transfer is active, is ignored.
- R11: Read strobes that arrive while the synchronised acknowledge is high neither pop the FIFO nor change `bus_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Push one word into the FIFO |
| load_data_i | input | 16 | Word to push |
| fifo_full_o | output | 1 | FIFO holds FIFO_DEPTH words |
| start_i | input | 1 | Begin a transfer |
| start_len_i | input | 16 | Transfer length in words |
| irq_clr_i | input | 1 | Clear the interrupt |
| host_ack_n_i | input | 1 | Host DMA acknowledge, active low, asynchronous |
| host_rd_n_i | input | 1 | Host read strobe, active low, asynchronous |
| host_chan_sel_i | input | 1 | Host address selects the DMA channel |
| xfer_req_o | output | 1 | DMA request to host, active high |
| bus_data_o | output | 16 | Word presented to the shared bus |
| bus_oe_o | output | 1 | Drive enable for the bus pads |
| sector_done_o | output | 1 | One-cycle pulse per completed 1024-word sector |
| xfer_done_o | output | 1 | One-cycle pulse on the last word |
| irq_o | output | 1 | Interrupt request, held until cleared |

## Verification
The bench covers these corner cases:
- A starved FIFO at a burst boundary. A design that held the request there would let the host read words that have not arrived.
- A refill during a pause. The request has to come back when enough words are present, or the host stalls forever.
- A final burst shorter than 16 words, where the readiness threshold must shrink to the number of words remaining.
- Strobes that arrive while acknowledge is high. A design that popped on them would skip words, and the skip shows up as a data miscompare later.
- A restart during an active transfer, and FIFO overflow. Both would corrupt the word order or the transfer length.
- The sector pulse on word 1024, and the exact three-edge latency of the strobe path.

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  // Next value of a counter that wraps to zero at lim.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Words needed before a new burst may be requested.
  function automatic int unsigned burst_need(input int unsigned remaining, input int unsigned burst);
    return (remaining < burst) ? remaining : burst;
  endfunction

  // True when the FIFO level covers the next burst.
  function automatic logic words_ready(input int unsigned level, input int unsigned remaining,
                                       input int unsigned burst);
    return level >= burst_need(remaining, burst);
  endfunction

endpackage

// File: rtl/dtx_sync2.sv
module dtx_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= RST_VAL;
      sync_o <= RST_VAL;
    end else begin
      stage1 <= async_i;
      sync_o <= stage1;
    end
  end
endmodule

// File: rtl/dtx_fifo.sv
module dtx_fifo
  import dtx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   level_o,
  output logic                         full_o,
  output logic                         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= AW'(wrap_inc(32'(wr_ptr), DEPTH));
      if (rd_en) rd_ptr <= AW'(wrap_inc(32'(rd_ptr), DEPTH));
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign level_o = count;
  assign full_o  = (count == CW'(DEPTH));
  assign empty_o = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full_o) else $error("push into full FIFO"); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty_o) else $error("pop from empty FIFO"); // R5
endmodule

// File: rtl/burst_dma_tx.sv
module burst_dma_tx
  import dtx_pkg::*;
#(
  parameter int DW           = 16,
  parameter int FIFO_DEPTH   = 32,
  parameter int BURST_WORDS  = 16,
  parameter int SECTOR_WORDS = 1024,
  parameter int LEN_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DW-1:0]    load_data_i,
  output logic             fifo_full_o,
  input  logic             start_i,
  input  logic [LEN_W-1:0] start_len_i,
  input  logic             irq_clr_i,
  input  logic             host_ack_n_i,
  input  logic             host_rd_n_i,
  input  logic             host_chan_sel_i,
  output logic             xfer_req_o,
  output logic [DW-1:0]    bus_data_o,
  output logic             bus_oe_o,
  output logic             sector_done_o,
  output logic             xfer_done_o,
  output logic             irq_o
);
  localparam int BW = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
  localparam int SW = (SECTOR_WORDS > 1) ? $clog2(SECTOR_WORDS) : 1;
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  // Synchronised host controls.
  logic rd_lvl, rd_prev, ack_lvl;
  dtx_sync2 #(.RST_VAL(1'b1)) u_rd_sync  (.clk(clk), .rst_n(rst_n), .async_i(host_rd_n_i),  .sync_o(rd_lvl));
  dtx_sync2 #(.RST_VAL(1'b1)) u_ack_sync (.clk(clk), .rst_n(rst_n), .async_i(host_ack_n_i), .sync_o(ack_lvl));

  // Word buffer.
  logic          push_ev, pop_ev, fifo_empty;
  logic [DW-1:0] fifo_head;
  logic [LW-1:0] fifo_level;
  dtx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(push_ev), .wr_data(load_data_i),
    .rd_en(pop_ev), .rd_data(fifo_head), .level_o(fifo_level),
    .full_o(fifo_full_o), .empty_o(fifo_empty)
  );

  // Transfer state.
  logic [LEN_W-1:0] words_left;
  logic [BW-1:0]    burst_pos;
  logic [SW-1:0]    sector_pos;
  logic             req_q, oe_q, sdone_q, xdone_q, irq_q;
  logic [DW-1:0]    bus_word;

  // Named internal events.
  logic active, rd_fall, start_ok, last_word, sector_wrap, burst_open, data_ready;

  assign active      = (words_left != '0);
  assign rd_fall     = rd_prev & ~rd_lvl;
  assign push_ev     = load_i & ~fifo_full_o;
  assign pop_ev      = rd_fall & ~ack_lvl & active & ~fifo_empty;
  assign start_ok    = start_i & ~active & (start_len_i != '0);
  assign last_word   = pop_ev & (words_left == LEN_W'(1));
  assign sector_wrap = pop_ev & (sector_pos == SW'(SECTOR_WORDS - 1));
  assign burst_open  = (burst_pos != '0);
  assign data_ready  = words_ready(32'(fifo_level), 32'(words_left), BURST_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev    <= 1'b1;
      words_left <= '0;
      burst_pos  <= '0;
      sector_pos <= '0;
      req_q      <= 1'b0;
      oe_q       <= 1'b0;
      sdone_q    <= 1'b0;
      xdone_q    <= 1'b0;
      irq_q      <= 1'b0;
      bus_word   <= '0;
    end else begin
      rd_prev <= rd_lvl;
      req_q   <= active & (burst_open | data_ready);
      oe_q    <= ~host_ack_n_i & host_chan_sel_i;
      sdone_q <= sector_wrap;
      xdone_q <= last_word;
      if (start_ok) begin
        words_left <= start_len_i;
        burst_pos  <= '0;
        sector_pos <= '0;
      end else if (pop_ev) begin
        words_left <= words_left - LEN_W'(1);
        burst_pos  <= BW'(wrap_inc(32'(burst_pos), BURST_WORDS));
        sector_pos <= SW'(wrap_inc(32'(sector_pos), SECTOR_WORDS));
      end
      if (pop_ev) bus_word <= fifo_head;
      if (last_word)      irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
    end
  end

  assign xfer_req_o    = req_q;
  assign bus_oe_o      = oe_q;
  assign bus_data_o    = bus_word;
  assign sector_done_o = sdone_q;
  assign xfer_done_o   = xdone_q;
  assign irq_o         = irq_q;

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack_n_i |=> !bus_oe_o) else $error("bus held after ack"); // R2
  AST_REQ_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !xfer_req_o) else $error("request after last word"); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !xfer_done_o) else $error("done longer than a cycle"); // R7
  AST_SECTOR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sector_done_o |=> !sector_done_o) else $error("sector pulse too long"); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o) else $error("irq lost"); // R8
  AST_NO_POP_ACK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_data_o) |-> !$past(ack_lvl)) else $error("word moved with ack high"); // R11
endmodule

// File: tb/burst_dma_tx_test.sv
module burst_dma_tx_test;
  localparam int DEPTH = 32;
  localparam int RD_HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic [15:0] load_data_i = '0;
  logic fifo_full_o;
  logic start_i = 1'b0;
  logic [15:0] start_len_i = '0;
  logic irq_clr_i = 1'b0;
  logic host_ack_n_i = 1'b1;
  logic host_rd_n_i = 1'b1;
  logic host_chan_sel_i = 1'b0;
  logic xfer_req_o, bus_oe_o, sector_done_o, xfer_done_o, irq_o;
  logic [15:0] bus_data_o;

  always #2.5 clk = ~clk;

  burst_dma_tx uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_data_i(load_data_i),
    .fifo_full_o(fifo_full_o), .start_i(start_i), .start_len_i(start_len_i),
    .irq_clr_i(irq_clr_i), .host_ack_n_i(host_ack_n_i), .host_rd_n_i(host_rd_n_i),
    .host_chan_sel_i(host_chan_sel_i), .xfer_req_o(xfer_req_o), .bus_data_o(bus_data_o),
    .bus_oe_o(bus_oe_o), .sector_done_o(sector_done_o), .xfer_done_o(xfer_done_o),
    .irq_o(irq_o)
  );

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Stimulus controls set by scenarios.
  int feed_budget = 0;
  bit force_load = 1'b0;
  int feed_val = 16'h3C00;
  bit do_start = 1'b0;
  int start_len = 0;
  bit do_clr = 1'b0;

  // Reference model state.
  int q[$];
  int m_rem = 0, m_bpos = 0, m_spos = 0;
  bit m_rd1 = 1, m_rd2 = 1, m_rdp = 1, m_ack1 = 1, m_ack2 = 1;
  bit e_req = 0, e_oe = 0, e_sd = 0, e_xd = 0, e_irq = 0, e_full = 0;
  int e_bus = 0;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit load, input int data, input bit strt, input int len, input bit clr);
    bit fall, pop, push;
    int need;
    fall = m_rdp && !m_rd2;
    pop = fall && !m_ack2 && (m_rem != 0) && (q.size() != 0);
    need = (m_rem < 16) ? m_rem : 16;
    e_req = (m_rem != 0) && ((m_bpos != 0) || (q.size() >= need));
    e_oe = !host_ack_n_i && host_chan_sel_i;
    push = load && (q.size() < DEPTH);
    m_rdp = m_rd2; m_rd2 = m_rd1; m_rd1 = host_rd_n_i;
    m_ack2 = m_ack1; m_ack1 = host_ack_n_i;
    e_sd = 0; e_xd = 0;
    if (strt && m_rem == 0 && len != 0) begin
      m_rem = len; m_bpos = 0; m_spos = 0;
    end else if (pop) begin
      e_bus = q.pop_front();
      m_rem--;
      m_bpos = (m_bpos + 1) % 16;
      m_spos = (m_spos + 1) % 1024;
      e_sd = (m_spos == 0);
      e_xd = (m_rem == 0);
    end
    if (e_xd) e_irq = 1;
    else if (clr) e_irq = 0;
    if (push) q.push_back(data);
    e_full = (q.size() == DEPTH);
  endtask

  // Drive inputs for the next edge, advance the model, then compare at the next falling edge.
  task automatic tick();
    bit ld;
    ld = (feed_budget > 0) && (force_load || q.size() < DEPTH);
    load_i = ld;
    load_data_i = 16'(feed_val);
    start_i = do_start;
    start_len_i = 16'(start_len);
    irq_clr_i = do_clr;
    model_step(ld, feed_val, do_start, start_len, do_clr);
    if (ld) begin feed_budget--; feed_val = (feed_val * 5 + 16'h1D) & 16'hFFFF; end
    do_start = 0; do_clr = 0;
    @(negedge clk);
    check("R3", "xfer_req_o", 32'(xfer_req_o), 32'(e_req));
    check("R2", "bus_oe_o", 32'(bus_oe_o), 32'(e_oe));
    check("R5", "bus_data_o", 32'(bus_data_o), 32'(e_bus));
    check("R6", "sector_done_o", 32'(sector_done_o), 32'(e_sd));
    check("R7", "xfer_done_o", 32'(xfer_done_o), 32'(e_xd));
    check("R8", "irq_o", 32'(irq_o), 32'(e_irq));
    check("R1", "fifo_full_o", 32'(fifo_full_o), 32'(e_full));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wait_req();
    while (!xfer_req_o) tick();
  endtask

  task automatic burst(input int n);
    host_ack_n_i = 0; host_chan_sel_i = 1;
    ticks(4);
    for (int i = 0; i < n; i++) begin
      host_rd_n_i = 0; ticks(RD_HALF);
      host_rd_n_i = 1; ticks(RD_HALF);
    end
    host_ack_n_i = 1; host_chan_sel_i = 0;
    ticks(4);
  endtask

  task automatic run_xfer(input int len);
    int left;
    left = len;
    while (left > 0) begin
      int n;
      wait_req();
      n = (left < 16) ? left : 16;
      burst(n);
      left -= n;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset values
    check("R9", "req", 32'(xfer_req_o), 0);
    check("R9", "oe", 32'(bus_oe_o), 0);
    check("R9", "data", 32'(bus_data_o), 0);
    check("R9", "flags", 32'({sector_done_o, xfer_done_o, irq_o, fifo_full_o}), 0);
    rst_n = 1;
    ticks(3);

    // R10: zero-length start ignored, even with data buffered
    feed_budget = 20;
    do_start = 1; start_len = 0;
    ticks(30);
    check("R10", "req after zero-length start", 32'(xfer_req_o), 0);

    // Transfer of 40 words with a starved FIFO at the first boundary (R4)
    do_start = 1; start_len = 40;
    tick();
    wait_req();
    burst(16);
    ticks(6);
    check("R4", "req paused with 4 words buffered", 32'(xfer_req_o), 0);
    // R11: strobes with acknowledge high are ignored
    for (int i = 0; i < 3; i++) begin
      host_rd_n_i = 0; ticks(RD_HALF);
      host_rd_n_i = 1; ticks(RD_HALF);
    end
    check("R11", "bus word after strobes with ack high", 32'(bus_data_o), 32'(e_bus));
    feed_budget = 20;
    wait_req();
    check("R4", "req back after refill", 32'(xfer_req_o), 1);
    burst(16);
    wait_req();
    burst(8);
    ticks(4);
    check("R7", "irq after last word", 32'(irq_o), 1);
    check("R7", "req low after end", 32'(xfer_req_o), 0);
    do_clr = 1;
    ticks(2);
    check("R8", "irq cleared", 32'(irq_o), 0);

    // Long transfer across a sector boundary, with a restart attempt mid-way (R10, R6)
    feed_budget = 1030;
    do_start = 1; start_len = 1030;
    tick();
    wait_req();
    do_start = 1; start_len = 5;
    tick();
    run_xfer(1030);
    ticks(4);
    check("R7", "irq after long transfer", 32'(irq_o), 1);
    do_clr = 1;
    tick();

    // Overflow: pushes while full are dropped (R1)
    force_load = 1;
    feed_budget = 40;
    ticks(42);
    check("R1", "full after overflow", 32'(fifo_full_o), 1);
    force_load = 0;
    do_start = 1; start_len = 32;
    tick();
    run_xfer(32);
    ticks(4);
    check("R1", "fifo drained", 32'(fifo_full_o), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule